// File: doc/BRIEF.md
# Lockable Output Pin Remapping Matrix

This block decides, pin by pin, which peripheral output signal reaches each remappable device pin. Every pin owns a small select register; the code held there names one of up to fifteen peripheral sources. Code zero, and any code above the number of implemented peripherals, leaves the pin dark: its output-enable is low and its data is low. All select registers come out of reset at zero, so no peripheral reaches any pin until software programs the matrix.

Software reaches the matrix through a plain single-cycle register port. A write-protect flag guards the select registers. While the flag is set, writes to them complete without error and change nothing. The flag itself can be written only in the single cycle that follows a correct two-word key sequence. A one-way strap, normally tied high, makes the first setting of the flag final until the next reset. This yields exactly one configuration session per reset. The pin outputs are continuous levels and not a stream, so they have no valid/ready handshake. The register port never back-pressures: every write is taken in the cycle it is presented.

Top module: `pinmux_out_lockable`

## Requirements
- R1: After reset every select register reads 0, `pin_oe` and `pin_data` are all zero, and the status register reads 0.
- R2: A pin whose select code c lies in 1..NUM_SRC has `pin_oe` high and `pin_data` equal to `periph_data[c-1]`, following `periph_data` in the same cycle.
- R3: A pin whose code is 0, or greater than NUM_SRC, has `pin_oe` low and `pin_data` low.
- R4: While `lock_state` is high, a write to a select register leaves its contents and the pin outputs unchanged.
- R5: A write to the status address (NUM_PINS+1, bit 0 = lock value) takes effect only in the cycle right after the second key word is accepted. At any other time it is dropped.
- R6: The key sequence is a write of 32'hAA996655 to the key address (NUM_PINS), then a write of 32'h556699AA to that same address. The next write after the first key word must be the second key word: any other write in between aborts the sequence. Cycles without a write do not abort it.
- R7: With `one_way_en` high, the first accepted setting of the lock raises `one_way_used`. After that, any attempt to clear the lock is refused. Only reset clears the flag.
- R8: With `one_way_en` low, the lock can be set and cleared any number of times, each time after a fresh key sequence, and `one_way_used` stays low.
- R9: The read port is combinational and ignores the lock. At address p < NUM_PINS it returns pin p's select code in bits 3:0. At NUM_PINS+1 it returns the lock in bit 0 and `one_way_used` in bit 1. All other bits and addresses read 0.
- R10: A select write when unlocked updates only the addressed pin with `wr_data[3:0]`, visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| one_way_en | input | 1 | Strap: makes the first lock setting final |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data (combinational) |
| periph_data | input | NUM_SRC | Peripheral output levels, bit i is source code i+1 |
| pin_data | output | NUM_PINS | Routed data for each pin |
| pin_oe | output | NUM_PINS | Output-enable for each pin |
| lock_state | output | 1 | Current write-protect flag |
| one_way_used | output | 1 | One-way session consumed |

## Verification
The bench aims at the key sequencer's edges. These are a lock write one idle cycle after the second key, which a design with a wider window would accept, and a stray write between the two key words, which a sequencer that does not abort would let through. An idle gap between the key words must not abort the sequence. A design that counts cycles instead of writes would refuse that legitimate unlock. It also checks the codes above the implemented range, which a plain mux would route to garbage or leave enabled. It tries a clear after a one-way set, which a design without the sticky flag would obey. Locked writes are checked through readback and through the pins, which catches a design that blocks the register but not the write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] KEY_FIRST  = 32'hAA996655;
  localparam logic [REG_W-1:0] KEY_SECOND = 32'h556699AA;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/pinmux_key_seq.sv
module pinmux_key_seq
  import pinmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             key_hit,
  input  logic [REG_W-1:0] wr_data,
  output logic             window_o
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
    end else begin
      case (state_q)
        KS_IDLE: if (wr_en && key_hit && wr_data == KEY_FIRST) state_q <= KS_HALF;
        KS_HALF: if (wr_en) state_q <= (key_hit && wr_data == KEY_SECOND) ? KS_OPEN : KS_IDLE;
        default: state_q <= KS_IDLE;
      endcase
    end
  end

  assign window_o = (state_q == KS_OPEN);

  // window lasts exactly one cycle (R5)
  assert_window_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    window_o |=> !window_o);
  // window only follows an accepted second key word (R6)
  assert_window_after_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    window_o |-> $past(wr_en && key_hit && wr_data == KEY_SECOND));
endmodule

// File: rtl/pinmux_lock_ctl.sv
module pinmux_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic window,
  input  logic lock_wr,
  input  logic lock_val,
  input  logic one_way_en,
  output logic lock_o,
  output logic used_o
);
  logic lock_q, used_q, accept;

  assign accept = window && lock_wr && !(used_q && !lock_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      used_q <= 1'b0;
    end else if (accept) begin
      lock_q <= lock_val;
      if (lock_val && one_way_en) used_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign used_o = used_q;

  // lock moves only on a write inside the key window (R5)
  assert_lock_needs_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(window && lock_wr));
  // once the one-way session is consumed the lock and flag stay set (R7)
  assert_one_way_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    used_q |=> (lock_q && used_q));
endmodule

// File: rtl/pinmux_pin_slice.sv
module pinmux_pin_slice #(
  parameter int SEL_W   = 4,
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic               locked,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [NUM_SRC-1:0] periph,
  output logic [SEL_W-1:0]   sel_o,
  output logic               pin_d,
  output logic               pin_oe
);
  localparam int N_CODES = 1 << SEL_W;

  logic [SEL_W-1:0]   sel_q;
  logic [N_CODES-1:0] src_ext, valid_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (wr_hit && !locked) sel_q <= wr_sel;
  end

  for (genvar c = 0; c < N_CODES; c++) begin : g_code
    if (c >= 1 && c <= NUM_SRC) begin : g_real
      assign src_ext[c]   = periph[c-1];
      assign valid_ext[c] = 1'b1;
    end else begin : g_null
      assign src_ext[c]   = 1'b0;
      assign valid_ext[c] = 1'b0;
    end
  end

  assign pin_d  = src_ext[sel_q];
  assign pin_oe = valid_ext[sel_q];
  assign sel_o  = sel_q;

  // select register only moves on an unlocked write to this pin (R4)
  assert_sel_guarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wr_hit && !locked));
  // null code drives nothing (R3)
  assert_null_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> (!pin_oe && !pin_d));
endmodule

// File: rtl/pinmux_out_lockable.sv
module pinmux_out_lockable
  import pinmux_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_SRC  = 12,
  parameter int SEL_W    = 4,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               one_way_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_SRC-1:0] periph_data,
  output logic [NUM_PINS-1:0] pin_data,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic               lock_state,
  output logic               one_way_used
);
  localparam int KEY_ADDR  = NUM_PINS;
  localparam int LOCK_ADDR = NUM_PINS + 1;

  logic             key_hit, lock_hit, window;
  logic             lock_q, used_q;
  logic [SEL_W-1:0] sel_all [NUM_PINS];

  assign key_hit  = (wr_addr == ADDR_W'(KEY_ADDR));
  assign lock_hit = wr_en && (wr_addr == ADDR_W'(LOCK_ADDR));

  pinmux_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .key_hit(key_hit),
    .wr_data(wr_data), .window_o(window)
  );

  pinmux_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .window(window), .lock_wr(lock_hit),
    .lock_val(wr_data[0]), .one_way_en(one_way_en),
    .lock_o(lock_q), .used_o(used_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_pin_slice #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (wr_addr == ADDR_W'(p))),
      .locked(lock_q), .wr_sel(wr_data[SEL_W-1:0]), .periph(periph_data),
      .sel_o(sel_all[p]), .pin_d(pin_data[p]), .pin_oe(pin_oe[p])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data[SEL_W-1:0] = sel_all[i];
    end
    if (rd_addr == ADDR_W'(LOCK_ADDR)) rd_data[1:0] = {used_q, lock_q};
  end

  assign lock_state   = lock_q;
  assign one_way_used = used_q;

  // with the strap low the one-way flag never rises (R8)
  assert_no_used_without_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_way_en && !one_way_used) |=> (!one_way_used || $past(one_way_en)));
  // an enabled pin always carries a routed level, a disabled one is low (R3)
  assert_dark_pins_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_oe) & pin_data) == '0);
endmodule

// File: tb/sim_pinmux_out_lockable.sv
module sim_pinmux_out_lockable;
  localparam int NP = 8;
  localparam int NS = 12;
  localparam logic [31:0] K1 = 32'hAA996655;
  localparam logic [31:0] K2 = 32'h556699AA;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, one_way_en, wr_en;
  logic [3:0]    wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic [NS-1:0] periph_data;
  logic [NP-1:0] pin_data, pin_oe;
  logic          lock_state, one_way_used;

  pinmux_out_lockable u0 (
    .clk(clk), .rst_n(rst_n), .one_way_en(one_way_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .periph_data(periph_data), .pin_data(pin_data), .pin_oe(pin_oe),
    .lock_state(lock_state), .one_way_used(one_way_used)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [3:0] m_sel [NP];

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = rd_data;
          1: act = 32'(pin_oe);
          default: act = 32'(pin_data);
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(4'd8, K1);
    wr(4'd8, K2);
  endtask

  task automatic chk_rd(logic [3:0] a, logic [31:0] e, string tag);
    rd_addr = a;
    q.push_back('{0, e, tag});
    @(posedge clk); #1;
  endtask

  task automatic chk_pins(string tag);
    logic [NP-1:0] eo, ed;
    eo = '0; ed = '0;
    for (int i = 0; i < NP; i++) begin
      if (m_sel[i] >= 4'd1 && int'(m_sel[i]) <= NS) begin
        eo[i] = 1'b1;
        ed[i] = periph_data[m_sel[i] - 4'd1];
      end
    end
    q.push_back('{1, 32'(eo), {tag, " oe"}});
    q.push_back('{2, 32'(ed), {tag, " data"}});
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    for (int i = 0; i < NP; i++) m_sel[i] = 4'd0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; one_way_en = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    periph_data = 12'hA5C;
    @(posedge clk); #1;
    do_reset();

    // R1 reset state
    chk_pins("R1 reset pins");
    chk_rd(4'd0, 32'd0, "R1 sel0");
    chk_rd(4'd7, 32'd0, "R1 sel7");
    chk_rd(4'd9, 32'd0, "R1 status");

    // R10 / R2 / R3 programming
    wr(4'd0, 32'd1);  m_sel[0] = 4'd1;
    wr(4'd1, 32'd12); m_sel[1] = 4'd12;
    wr(4'd2, 32'd5);  m_sel[2] = 4'd5;
    wr(4'd3, 32'd13); m_sel[3] = 4'd13;
    wr(4'd4, 32'd15); m_sel[4] = 4'd15;
    wr(4'd5, 32'd0);  m_sel[5] = 4'd0;
    wr(4'd6, 32'd8);  m_sel[6] = 4'd8;
    wr(4'd7, 32'hFFFF_FFF3); m_sel[7] = 4'd3;
    chk_rd(4'd1, 32'd12, "R10 pin1");
    chk_rd(4'd7, 32'd3,  "R10 low bits only");
    chk_rd(4'd3, 32'd13, "R9 unimplemented code readback");
    chk_rd(4'd10, 32'd0, "R9 unmapped address");
    chk_pins("R2 R3 routing");
    periph_data = ~periph_data;
    chk_pins("R2 follows new data");

    // R5 lock writes outside the window
    wr(4'd9, 32'd1);
    chk_rd(4'd9, 32'd0, "R5 no key");
    unlock(); idle(1); wr(4'd9, 32'd1);
    chk_rd(4'd9, 32'd0, "R5 one cycle late");

    // R6 intervening write aborts
    wr(4'd8, K1); wr(4'd0, 32'd2); m_sel[0] = 4'd2;
    wr(4'd8, K2); wr(4'd9, 32'd1);
    chk_rd(4'd9, 32'd0, "R6 aborted sequence");
    chk_rd(4'd0, 32'd2, "R6 stray write landed");

    // R6 idle gap allowed, R7 one-way flag set
    wr(4'd8, K1); idle(2); wr(4'd8, K2); wr(4'd9, 32'd1);
    chk_rd(4'd9, 32'd3, "R6 R7 gap accepted, used set");

    // R4 locked writes dropped
    wr(4'd2, 32'd7);
    chk_rd(4'd2, 32'd5, "R4 locked readback");
    chk_pins("R4 locked pins");

    // R7 clear refused
    unlock(); wr(4'd9, 32'd0);
    chk_rd(4'd9, 32'd3, "R7 clear refused");
    wr(4'd4, 32'd1);
    chk_rd(4'd4, 32'd15, "R7 still protected");

    // R8 strap low, reset clears everything (R1)
    one_way_en = 1'b0;
    do_reset();
    chk_rd(4'd9, 32'd0, "R1 status after reset");
    chk_rd(4'd2, 32'd0, "R1 sel after reset");
    unlock(); wr(4'd9, 32'd1);
    chk_rd(4'd9, 32'd1, "R8 set without used");
    wr(4'd2, 32'd9);
    chk_rd(4'd2, 32'd0, "R4 locked again");
    unlock(); wr(4'd9, 32'd0);
    chk_rd(4'd9, 32'd0, "R8 cleared");
    wr(4'd2, 32'd9); m_sel[2] = 4'd9;
    chk_rd(4'd2, 32'd9, "R8 writable again");
    chk_pins("R2 after second session");

    done = 1;
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule